// File: doc/BRIEF.md
# Waveform Zero-Suppression FIFO

This block buffers a stream of digitized detector samples, one byte per strobe, and keeps only the waveforms that carry enough signal. It cuts the input into fixed-length waveforms of `SAMPLES` bytes. Each waveform is written into a circular store as it arrives, and its bytes are summed at the same time. When the final byte of the waveform comes in, the sum is compared with a threshold. A waveform whose sum is strictly greater than the threshold becomes visible to the reader. Any other waveform is erased by moving the speculative write position back to the last committed position.

A downstream consumer drains the committed bytes in arrival order through a valid/ready handshake. A last flag marks the closing byte of every waveform. The store holds `WAVES` waveforms. If a waveform starts while the store lacks room for all of it, the whole waveform is refused and an overflow strobe is raised. The store never holds a partial waveform. The threshold is sampled once per waveform, on its first byte.

Top module: `wavesup_fifo`

## Requirements
- R1: Synchronous reset with `rst_n` low empties the store. Out of reset, `out_valid` and `overflow` are 0.
- R2: A waveform whose byte sum is strictly greater than the threshold is delivered on `out_data`. All `SAMPLES` bytes appear in input order, and the first byte is presented in the cycle after the edge that accepts the waveform's last input byte.
- R3: A waveform whose byte sum is less than or equal to the threshold never reaches the output. Its storage is released at the edge of its last byte.
- R4: Bytes of a waveform become visible only after that waveform is complete and kept. While `out_valid` is 1, all remaining bytes of the current waveform are already committed.
- R5: `out_last` is 1 exactly on the `SAMPLES`-th byte of each delivered waveform and 0 on every other byte.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value on the next cycle. A byte is consumed only on a cycle with both signals at 1.
- R7: If fewer than `SAMPLES` free byte slots remain (counting committed bytes not yet read) when a waveform's first byte arrives, none of that waveform is stored. `overflow` is 1 for exactly the one cycle after that first byte.
- R8: The threshold used for a waveform is the value on `thresh` when its first byte is accepted. Later changes during the same waveform do not affect its decision.
- R9: The sum is kept at 8 + ceil(log2(`SAMPLES`)) bits and does not wrap. A waveform of all 0xFF bytes has sum 255·`SAMPLES`.
- R10: Only cycles with `in_valid` at 1 carry samples. Idle cycles neither advance the position within a waveform nor change the sum.
- R11: The store never holds more than `SAMPLES`·`WAVES` committed bytes. Byte order is preserved when the pointers wrap around the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 8 | Sample byte |
| thresh | input | 8+ceil(log2(SAMPLES)) | Keep threshold (sum must exceed it) |
| out_valid | output | 1 | A committed byte is presented |
| out_ready | input | 1 | Consumer accepts the presented byte |
| out_data | output | 8 | Presented byte |
| out_last | output | 1 | Presented byte closes its waveform |
| overflow | output | 1 | One-cycle strobe: a waveform was refused for lack of room |

## Verification
The bench builds the block with `SAMPLES`=4 and `WAVES`=3, which gives a 12-byte store. With a store that small, three kept waveforms fill it completely, so the bench can reach both the exactly-full refusal and the partly-drained refusal (10 bytes held, 2 free) in a few dozen cycles. The read and write pointers also wrap many times during the random phase. A 10-bit threshold lets the bench reach the 1020 all-0xFF sum with thresholds of 1019 and 1020 on either side of it.

// File: rtl/wavesup_pkg.sv
// Shared types and helpers for the waveform zero-suppression FIFO.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package wavesup_pkg;
    typedef logic [7:0] sample_t;

    // Width of an index able to address n items (at least one bit).
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/wavesup_accum.sv
// Waveform framing and sum decision.
// Tracks the position inside the current waveform and accumulates its bytes.
// Latches the threshold on the first byte. On the last byte it issues keep
// or drop for an accepted waveform. A waveform is accepted only if the store
// reports room on its first byte; otherwise an overflow strobe follows.
// Assumes: the previous waveform is resolved before the next first byte.
module wavesup_accum #(
    parameter int unsigned SAMPLES = 8,
    parameter int unsigned SUM_W   = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  wavesup_pkg::sample_t      in_data,
    input  logic [SUM_W-1:0]          thr_in,
    input  logic                      room,
    output logic                      wr_en,
    output logic                      keep,
    output logic                      drop,
    output logic                      ovf
);
    localparam int unsigned IW = wavesup_pkg::bits_for(SAMPLES);
    localparam logic [IW-1:0] LAST_IDX = IW'(SAMPLES - 1);

    logic [IW-1:0]    idx_q;
    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] thr_q;
    logic             active_q;
    logic             ovf_q;

    logic             first, last, accept, above;
    logic [SUM_W-1:0] sum_now, thr_now;

    // Decision path for the byte present this cycle.
    always_comb begin
        first   = (idx_q == '0);
        last    = (idx_q == LAST_IDX);
        accept  = first ? room : active_q;
        sum_now = (first ? '0 : acc_q) + SUM_W'(in_data);
        thr_now = first ? thr_in : thr_q;
        above   = (sum_now > thr_now);
    end

    assign wr_en = in_valid && accept;
    assign keep  = in_valid && last && accept && above;
    assign drop  = in_valid && last && accept && !above;
    assign ovf   = ovf_q;

    // Position, running sum, latched threshold and acceptance per waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            acc_q    <= '0;
            thr_q    <= '0;
            active_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= in_valid && first && !room;
            if (in_valid) begin
                idx_q <= last ? '0 : idx_q + 1'b1;
                acc_q <= sum_now;
                if (first) begin
                    active_q <= room;
                    thr_q    <= thr_in;
                end
            end
        end
    end

    // R10: idle cycles leave framing and sum untouched.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(idx_q) && $stable(acc_q)));

    // R7: an overflow strobe always follows an incoming sample.
    a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $past(in_valid));
endmodule

// File: rtl/wavesup_store.sv
// Circular byte store with a committed and a speculative write pointer.
// Writes go to the speculative pointer. Keep advances the committed pointer
// to it; drop returns it to the committed pointer. Only committed bytes are
// counted and offered to the reader, one per valid/ready transfer.
// Assumes: keep/drop arrive on the last byte of a waveform, together with
// its write, and the caller writes only when room was granted.
module wavesup_store #(
    parameter int unsigned SAMPLES = 8,
    parameter int unsigned DEPTH   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  wavesup_pkg::sample_t wr_data,
    input  logic                 keep,
    input  logic                 drop,
    output logic                 room,
    output logic                 out_valid,
    input  logic                 out_ready,
    output wavesup_pkg::sample_t out_data,
    output logic                 out_last
);
    localparam int unsigned AW = wavesup_pkg::bits_for(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = wavesup_pkg::bits_for(SAMPLES);
    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(SAMPLES - 1);

    wavesup_pkg::sample_t mem [DEPTH];
    logic [AW-1:0] wp_spec_q, wp_com_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] rd_idx_q;
    logic [AW-1:0] spec_next, rd_next;
    logic          rd_fire;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == TOP_ADDR) ? '0 : p + 1'b1;
    endfunction

    // Next pointer values and read handshake.
    always_comb begin
        spec_next = step_ptr(wp_spec_q);
        rd_next   = step_ptr(rd_q);
        rd_fire   = out_valid && out_ready;
    end

    assign room      = (CW'(DEPTH) - cnt_q) >= CW'(SAMPLES);
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem[rd_q];
    assign out_last  = (rd_idx_q == LAST_IDX);

    // Byte storage, written speculatively.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_spec_q] <= wr_data;
    end

    // Pointer and committed-count maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_spec_q <= '0;
            wp_com_q  <= '0;
            rd_q      <= '0;
            cnt_q     <= '0;
            rd_idx_q  <= '0;
        end else begin
            if (keep) begin
                wp_spec_q <= spec_next;
                wp_com_q  <= spec_next;
            end else if (drop) begin
                wp_spec_q <= wp_com_q;
            end else if (wr_en) begin
                wp_spec_q <= spec_next;
            end
            cnt_q <= cnt_q + (keep ? CW'(SAMPLES) : '0) - (rd_fire ? CW'(1) : '0);
            if (rd_fire) begin
                rd_q     <= rd_next;
                rd_idx_q <= (rd_idx_q == LAST_IDX) ? '0 : rd_idx_q + 1'b1;
            end
        end
    end

    // R11: committed bytes never exceed the store size.
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R7: a kept waveform always had space reserved for it.
    a_r7_keep_fits: assert property (@(posedge clk) disable iff (!rst_n)
        keep |-> (int'(cnt_q) + int'(SAMPLES) <= int'(DEPTH)));

    // R4: the rest of the waveform under read is already committed.
    a_r4_whole_wave: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(cnt_q) >= int'(SAMPLES) - int'(rd_idx_q)));
endmodule

// File: rtl/wavesup_fifo.sv
// Waveform zero-suppression FIFO top.
// Splits the byte stream into waveforms of SAMPLES bytes and stores each
// speculatively. A waveform is kept when its byte sum exceeds the threshold
// latched at its first byte; otherwise it is erased. Kept bytes drain through
// a valid/ready port with a last flag per waveform.
// Assumes: a single clock; input samples cannot be back-pressured.
module wavesup_fifo #(
    parameter int unsigned SAMPLES = 8,
    parameter int unsigned WAVES   = 4,
    localparam int unsigned DEPTH  = SAMPLES * WAVES,
    localparam int unsigned SUM_W  = 8 + $clog2(SAMPLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [SUM_W-1:0] thresh,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             overflow
);
    logic wr_en, keep, drop, room;

    wavesup_accum #(.SAMPLES(SAMPLES), .SUM_W(SUM_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .thr_in   (thresh),
        .room     (room),
        .wr_en    (wr_en),
        .keep     (keep),
        .drop     (drop),
        .ovf      (overflow)
    );

    wavesup_store #(.SAMPLES(SAMPLES), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (in_data),
        .keep      (keep),
        .drop      (drop),
        .room      (room),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // R6: a stalled byte stays offered and unchanged.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/wavesup_fifo_tb_top.sv
// Bench: behavioural reference model with queues, compared every cycle,
// plus directed checks at the ports.
module wavesup_fifo_tb_top;
    localparam int M = 4;
    localparam int N = 3;
    localparam int D = M * N;
    localparam int SW = 8 + $clog2(M);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic [SW-1:0] thresh = '0;
    logic          out_ready = 1'b0;
    logic          out_valid, out_last, overflow;
    logic [7:0]    out_data;

    int checks = 0;
    int fails = 0;

    // reference model state
    logic [7:0] q_d[$];
    bit         q_l[$];
    logic [7:0] infl[$];
    int  m_idx = 0, m_acc = 0, m_thr = 0;
    bit  m_active = 0, exp_ovf = 0;
    int  ovf_seen = 0, pops = 0, last_pops = 0;

    always #4 clk = ~clk;

    wavesup_fifo #(.SAMPLES(M), .WAVES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .thresh(thresh), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every port against the model.
    task automatic compare();
        chk(out_valid == (q_d.size() != 0), "R2 out_valid", int'(out_valid), int'(q_d.size() != 0));
        if (q_d.size() != 0 && out_valid) begin
            chk(out_data == q_d[0], "R2 out_data", int'(out_data), int'(q_d[0]));
            chk(out_last == q_l[0], "R5 out_last", int'(out_last), int'(q_l[0]));
        end
        chk(overflow == exp_ovf, "R7 overflow", int'(overflow), int'(exp_ovf));
        if (overflow) ovf_seen++;
    endtask

    // One clock: drive at negedge, update model at posedge, compare at negedge.
    task automatic cyc(input bit v, input logic [7:0] d, input bit rdy);
        bit room, first;
        in_valid = v; in_data = d; out_ready = rdy;
        @(posedge clk);
        room = (D - q_d.size()) >= M;
        exp_ovf = 0;
        if (rdy && q_d.size() != 0) begin
            pops++;
            if (q_l[0]) last_pops++;
            void'(q_d.pop_front());
            void'(q_l.pop_front());
        end
        if (v) begin
            first = (m_idx == 0);
            if (first) begin
                m_active = room; m_thr = int'(thresh); m_acc = 0; infl.delete();
                if (!room) exp_ovf = 1;
            end
            m_acc += int'(d);
            if (m_active) infl.push_back(d);
            if (m_idx == M - 1) begin
                if (m_active && m_acc > m_thr) begin
                    for (int i = 0; i < M; i++) begin
                        q_d.push_back(infl[i]);
                        q_l.push_back(i == M - 1);
                    end
                end
                m_idx = 0;
            end else m_idx++;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic wave(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input logic [7:0] e, input bit rdy);
        cyc(1, a, rdy); cyc(1, b, rdy); cyc(1, c, rdy); cyc(1, e, rdy);
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) cyc(0, 0, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: empty and quiet after reset
        chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(overflow == 0, "R1 overflow after reset", int'(overflow), 0);

        // R2: kept waveform, sum 100 > 50, appears after last byte
        thresh = 50;
        cyc(1, 10, 0); cyc(1, 20, 0); cyc(1, 30, 0);
        chk(out_valid == 0, "R4 nothing before last byte", int'(out_valid), 0);
        cyc(1, 40, 0);
        chk(out_valid == 1 && out_data == 10, "R2 first byte visible", int'(out_data), 10);
        drain();

        // R3: sum equal to threshold is dropped
        thresh = 100;
        wave(25, 25, 25, 25, 1);
        chk(out_valid == 0, "R3 equal sum dropped", int'(out_valid), 0);
        wave(0, 0, 0, 0, 1);
        chk(out_valid == 0, "R3 zero waveform dropped", int'(out_valid), 0);
        drain();

        // R8: threshold raised/lowered mid-waveform has no effect
        thresh = 100; cyc(1, 50, 1); thresh = 10; cyc(1, 10, 1); cyc(1, 10, 1); cyc(1, 10, 1);
        chk(out_valid == 0, "R8 later lower threshold ignored", int'(out_valid), 0);
        thresh = 10; cyc(1, 50, 1); thresh = 200; cyc(1, 10, 1); cyc(1, 10, 1); cyc(1, 10, 1);
        chk(out_valid == 1 && out_data == 50, "R8 later higher threshold ignored", int'(out_valid), 1);
        drain();

        // R10: idle gaps inside a waveform
        thresh = 30;
        cyc(1, 10, 1); cyc(0, 99, 1); cyc(1, 10, 1); cyc(0, 99, 1); cyc(0, 99, 1);
        cyc(1, 10, 1);
        chk(out_valid == 0, "R10 gaps do not count as samples", int'(out_valid), 0);
        cyc(1, 5, 1);
        chk(out_valid == 1 && out_data == 10, "R10 waveform completes after gaps", int'(out_data), 10);
        drain();

        // R9: full-scale sum 1020 vs thresholds 1019 and 1020
        thresh = 1019;
        wave(8'hFF, 8'hFF, 8'hFF, 8'hFF, 0);
        chk(out_valid == 1, "R9 all-FF kept above 1019", int'(out_valid), 1);
        drain();
        thresh = 1020;
        wave(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1);
        chk(out_valid == 0, "R9 all-FF dropped at 1020", int'(out_valid), 0);
        drain();

        // R7: fill the store, then a waveform is refused whole
        thresh = 0; ovf_seen = 0;
        wave(1, 2, 3, 4, 0); wave(5, 6, 7, 8, 0); wave(9, 10, 11, 12, 0);
        wave(13, 14, 15, 16, 0);
        chk(ovf_seen == 1, "R7 one overflow strobe when full", ovf_seen, 1);
        // R6: stalled output holds
        chk(out_valid == 1 && out_data == 1, "R6 head held under stall", int'(out_data), 1);
        // partial drain leaves 10 bytes: still no room
        cyc(0, 0, 1); cyc(0, 0, 1);
        ovf_seen = 0;
        wave(20, 21, 22, 23, 0);
        chk(ovf_seen == 1, "R7 refused with 2 free slots", ovf_seen, 1);
        pops = 0; last_pops = 0;
        for (int i = 0; i < 30; i++) cyc(0, 0, (i % 3) != 1);
        chk(pops == 10, "R11 bytes drained", pops, 10);
        chk(last_pops == 3, "R5 last flags drained", last_pops, 3);
        chk(out_valid == 0, "R7 refused bytes never appear", int'(out_valid), 0);

        // R11: random traffic across many pointer wraps
        for (int i = 0; i < 4000; i++) begin
            if (m_idx == 0) thresh = SW'($urandom_range(0, 600));
            cyc($urandom_range(0, 3) != 0, 8'($urandom_range(0, 255)), $urandom_range(0, 2) != 0);
        end
        drain();
        chk(out_valid == 0, "R11 empty after final drain", int'(out_valid), 0);

        // R1: reset mid-traffic empties the store
        wave(200, 200, 200, 200, 0);
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        q_d.delete(); q_l.delete(); infl.delete(); m_idx = 0; exp_ovf = 0;
        chk(out_valid == 0, "R1 reset clears stored data", int'(out_valid), 0);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule